// File: doc/BRIEF.md
# RGBI to parallel DVI colour mapper

This block sits between a 4-bit RGBI pixel source and the 24-bit parallel RGB input of a DVI transmitter. On that input only the top two bits of each 8-bit channel are wired. The mapper drives those two bits and keeps the lower bits at zero. Red and blue each take their base colour bit and the shared intensity bit. Green has its own intensity output, so the mapper can produce the brown that a colour monitor shows for the dark yellow code.

The mapper has two modes. In colour mode it applies the brown rule. In monochrome mode it treats one input bit as the video dot and another as intensity, and it tints the lit dots with one of four colours. Two switch inputs pick the tint, and the choice can change while the block is running. Horizontal sync, vertical sync and display enable pass through the same single register stage as the colour, so every output has the same latency. While display enable is low, the colour outputs are zero.

Top module: `rgbi_dvi_mapper`

## Requirements
- R1: `pix_rgbi` is ordered {I,R,G,B} from bit 3 down to bit 0. In colour mode, `red_o[7]`=R, `blu_o[7]`=B, and `red_o[6]`=`blu_o[6]`=I. In both modes, bits 5:0 of every channel are always zero.
- R2: In colour mode, `grn_o[7]`=G and `grn_o[6]`=I. The one exception is code 4'b0110 (I=0 R=1 G=1 B=0), which gives `grn_o[7]`=0 and `grn_o[6]`=1 (brown).
- R3: In monochrome mode (`mono_mode`=1), `pix_rgbi[1]` is the video dot and `pix_rgbi[3]` is intensity. The R and B bits have no effect. An unlit dot drives all channels to zero. A lit dot sets bit 7 of each enabled channel, and sets bit 6 of those channels as well when intensity is 1.
- R4: `tint_sel` selects the enabled channels: 2'b00 green, 2'b01 red+green (yellow), 2'b10 red+green+blue (white), 2'b11 red. A new selection applies to the pixel registered at the next clock edge.
- R5: When the registered display enable is low, all 24 colour bits are zero.
- R6: `hs_o`, `vs_o`, `de_o` and the colour outputs each equal their inputs from one clock edge earlier.
- R7: While `rst_n` is low, all outputs are zero. Release passes through a two-flop synchroniser, so the output register first captures input on the third rising edge after release.
- R8: A change of `mono_mode` affects only the pixel registered at the next edge. The brown rule never applies in monochrome mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mono_mode | input | 1 | 1 = monochrome tint mapping, 0 = colour mapping |
| tint_sel | input | 2 | Monochrome tint select |
| pix_rgbi | input | 4 | Pixel {I,R,G,B} |
| hs_i | input | 1 | Horizontal sync in |
| vs_i | input | 1 | Vertical sync in |
| de_i | input | 1 | Display enable in |
| red_o | output | CH_W | Red channel to transmitter |
| grn_o | output | CH_W | Green channel to transmitter |
| blu_o | output | CH_W | Blue channel to transmitter |
| hs_o | output | 1 | Registered horizontal sync |
| vs_o | output | 1 | Registered vertical sync |
| de_o | output | 1 | Registered display enable |

## Verification
The properties assume that the inputs are stable around each rising clock edge. They also assume that every input, including the mode and tint controls, may change every cycle. The checks are armed only after the reset synchroniser has released and one capture has taken place. The stimulus changes inputs only on falling edges and changes mode and tint between consecutive vectors, so the one-cycle switching behaviour is covered. Reset is asserted away from clock edges so the asynchronous clear can be seen directly.

// File: rtl/rgbi_dvi_pkg.sv
`timescale 1ns/1ps
package rgbi_dvi_pkg;
  // two driven bits of one channel: msb and the one below it
  typedef struct packed {
    logic hi;
    logic lo;
  } lvl_t;

  typedef struct packed {
    logic i;
    logic r;
    logic g;
    logic b;
  } pix_t;

  typedef enum logic [1:0] {
    TINT_GREEN  = 2'd0,
    TINT_YELLOW = 2'd1,
    TINT_WHITE  = 2'd2,
    TINT_RED    = 2'd3
  } tint_e;

  localparam int NCH    = 3;
  localparam int CH_RED = 0;
  localparam int CH_GRN = 1;
  localparam int CH_BLU = 2;
endpackage

// File: rtl/rgbi_rst_sync.sv
`timescale 1ns/1ps
module rgbi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/rgbi_cga_map.sv
`timescale 1ns/1ps
module rgbi_cga_map
  import rgbi_dvi_pkg::*;
(
  input  pix_t           pix,
  output lvl_t [NCH-1:0] lvl
);
  logic brown;

  always_comb begin
    // dark yellow code shown as brown: green halved
    brown          = !pix.i && pix.r && pix.g && !pix.b;
    lvl[CH_RED].hi = pix.r;
    lvl[CH_RED].lo = pix.i;
    lvl[CH_GRN].hi = pix.g & ~brown;
    lvl[CH_GRN].lo = pix.i | brown;
    lvl[CH_BLU].hi = pix.b;
    lvl[CH_BLU].lo = pix.i;
  end
endmodule

// File: rtl/rgbi_mono_tint.sv
`timescale 1ns/1ps
module rgbi_mono_tint
  import rgbi_dvi_pkg::*;
(
  input  pix_t           pix,
  input  tint_e          tint,
  output lvl_t [NCH-1:0] lvl
);
  logic [NCH-1:0] ch_en;

  always_comb begin
    case (tint)
      TINT_GREEN:  ch_en = 3'b010;
      TINT_YELLOW: ch_en = 3'b011;
      TINT_WHITE:  ch_en = 3'b111;
      TINT_RED:    ch_en = 3'b001;
      default:     ch_en = 3'b000;
    endcase
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_comb begin
      lvl[c].hi = pix.g & ch_en[c];
      lvl[c].lo = pix.g & ch_en[c] & pix.i;
    end
  end
endmodule

// File: rtl/rgbi_out_stage.sv
`timescale 1ns/1ps
module rgbi_out_stage
  import rgbi_dvi_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_en,
  input  lvl_t [NCH-1:0]      lvl_d,
  input  logic                hs_d,
  input  logic                vs_d,
  input  logic                de_d,
  output logic [CH_W-1:0]     chan_q [NCH],
  output logic                hs_q,
  output logic                vs_q,
  output logic                de_q
);
  localparam int PAD_W = CH_W - 2;

  logic [CH_W-1:0] chan_d [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_comb begin
      if (de_d) chan_d[c] = {lvl_d[c].hi, lvl_d[c].lo, {PAD_W{1'b0}}};
      else      chan_d[c] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      chan_q[c] <= '0;
      else if (cap_en) chan_q[c] <= chan_d[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
      de_q <= 1'b0;
    end else if (cap_en) begin
      hs_q <= hs_d;
      vs_q <= vs_d;
      de_q <= de_d;
    end
  end
endmodule

// File: rtl/rgbi_dvi_mapper.sv
`timescale 1ns/1ps
module rgbi_dvi_mapper
  import rgbi_dvi_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mono_mode,
  input  logic [1:0]      tint_sel,
  input  logic [3:0]      pix_rgbi,
  input  logic            hs_i,
  input  logic            vs_i,
  input  logic            de_i,
  output logic [CH_W-1:0] red_o,
  output logic [CH_W-1:0] grn_o,
  output logic [CH_W-1:0] blu_o,
  output logic            hs_o,
  output logic            vs_o,
  output logic            de_o
);
  logic           rst_i_n;
  pix_t           pix;
  tint_e          tint;
  lvl_t [NCH-1:0] lvl_cga;
  lvl_t [NCH-1:0] lvl_mono;
  lvl_t [NCH-1:0] lvl_sel;
  logic [CH_W-1:0] chan_q [NCH];

  assign pix  = pix_t'(pix_rgbi);
  assign tint = tint_e'(tint_sel);

  rgbi_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  rgbi_cga_map u_cga (
    .pix (pix),
    .lvl (lvl_cga)
  );

  rgbi_mono_tint u_mono (
    .pix  (pix),
    .tint (tint),
    .lvl  (lvl_mono)
  );

  always_comb begin
    lvl_sel = mono_mode ? lvl_mono : lvl_cga;
  end

  rgbi_out_stage #(.CH_W(CH_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .cap_en (1'b1),
    .lvl_d  (lvl_sel),
    .hs_d   (hs_i),
    .vs_d   (vs_i),
    .de_d   (de_i),
    .chan_q (chan_q),
    .hs_q   (hs_o),
    .vs_q   (vs_o),
    .de_q   (de_o)
  );

  assign red_o = chan_q[CH_RED];
  assign grn_o = chan_q[CH_GRN];
  assign blu_o = chan_q[CH_BLU];
endmodule

// File: rtl/rgbi_dvi_mapper_chk.sv
`timescale 1ns/1ps
module rgbi_dvi_mapper_chk #(
  parameter int CH_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mono_mode,
  input logic [1:0]      tint_sel,
  input logic [3:0]      pix_rgbi,
  input logic            hs_i,
  input logic            vs_i,
  input logic            de_i,
  input logic [CH_W-1:0] red_o,
  input logic [CH_W-1:0] grn_o,
  input logic [CH_W-1:0] blu_o,
  input logic            hs_o,
  input logic            vs_o,
  input logic            de_o
);
  logic [2:0] edge_cnt;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              edge_cnt <= '0;
    else if (edge_cnt != 3'd5) edge_cnt <= edge_cnt + 3'd1;
  end
  assign armed = (edge_cnt >= 3'd4);

  // R1
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (red_o[CH_W-3:0] == '0) && (grn_o[CH_W-3:0] == '0) && (blu_o[CH_W-3:0] == '0));

  // R2
  brown_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(de_i && !mono_mode && pix_rgbi == 4'b0110)
      |-> grn_o[CH_W-1:CH_W-2] == 2'b01);

  // R3
  mono_unlit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(mono_mode && !pix_rgbi[1])
      |-> (red_o == '0) && (grn_o == '0) && (blu_o == '0));

  // R5
  blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !de_o |-> (red_o == '0) && (grn_o == '0) && (blu_o == '0));

  // R6
  sync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (hs_o == $past(hs_i)) && (vs_o == $past(vs_i)) && (de_o == $past(de_i)));

  // R7
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_cnt < 3'd3) |-> !de_o && !hs_o && !vs_o);
endmodule

bind rgbi_dvi_mapper rgbi_dvi_mapper_chk #(.CH_W(CH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mono_mode (mono_mode),
  .tint_sel  (tint_sel),
  .pix_rgbi  (pix_rgbi),
  .hs_i      (hs_i),
  .vs_i      (vs_i),
  .de_i      (de_i),
  .red_o     (red_o),
  .grn_o     (grn_o),
  .blu_o     (blu_o),
  .hs_o      (hs_o),
  .vs_o      (vs_o),
  .de_o      (de_o)
);

// File: tb/tb_rgbi_dvi_mapper.sv
`timescale 1ns/1ps
module tb_rgbi_dvi_mapper;
  logic       clk;
  logic       rst_n;
  logic       mono_mode;
  logic [1:0] tint_sel;
  logic [3:0] pix_rgbi;
  logic       hs_i, vs_i, de_i;
  logic [7:0] red_o, grn_o, blu_o;
  logic       hs_o, vs_o, de_o;

  int n_chk;
  int n_fail;
  bit done;

  rgbi_dvi_mapper #(.CH_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .mono_mode(mono_mode), .tint_sel(tint_sel),
    .pix_rgbi(pix_rgbi), .hs_i(hs_i), .vs_i(vs_i), .de_i(de_i),
    .red_o(red_o), .grn_o(grn_o), .blu_o(blu_o),
    .hs_o(hs_o), .vs_o(vs_o), .de_o(de_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {mono, tint[1:0], pix IRGB, de, red, grn, blu}
  localparam int NV = 20;
  localparam logic [31:0] VEC [NV] = '{
    {1'b0, 2'd0, 4'b0000, 1'b1, 8'h00, 8'h00, 8'h00}, // R1 black
    {1'b0, 2'd0, 4'b0100, 1'b1, 8'h80, 8'h00, 8'h00}, // R1 red
    {1'b0, 2'd0, 4'b0010, 1'b1, 8'h00, 8'h80, 8'h00}, // R2 green
    {1'b0, 2'd0, 4'b0001, 1'b1, 8'h00, 8'h00, 8'h80}, // R1 blue
    {1'b0, 2'd0, 4'b0110, 1'b1, 8'h80, 8'h40, 8'h00}, // R2 brown
    {1'b0, 2'd0, 4'b1110, 1'b1, 8'hC0, 8'hC0, 8'h40}, // R2 bright yellow
    {1'b0, 2'd0, 4'b1000, 1'b1, 8'h40, 8'h40, 8'h40}, // R1 dark grey
    {1'b0, 2'd0, 4'b1111, 1'b1, 8'hC0, 8'hC0, 8'hC0}, // R1 white
    {1'b0, 2'd0, 4'b0111, 1'b1, 8'h80, 8'h80, 8'h80}, // R2 light grey
    {1'b0, 2'd0, 4'b1101, 1'b1, 8'hC0, 8'h40, 8'hC0}, // R1 magenta
    {1'b0, 2'd0, 4'b1111, 1'b0, 8'h00, 8'h00, 8'h00}, // R5 blank
    {1'b1, 2'd0, 4'b0010, 1'b1, 8'h00, 8'h80, 8'h00}, // R8 R3 green
    {1'b1, 2'd0, 4'b1010, 1'b1, 8'h00, 8'hC0, 8'h00}, // R3 bright green
    {1'b1, 2'd1, 4'b0010, 1'b1, 8'h80, 8'h80, 8'h00}, // R4 yellow
    {1'b1, 2'd2, 4'b1010, 1'b1, 8'hC0, 8'hC0, 8'hC0}, // R4 white
    {1'b1, 2'd3, 4'b0010, 1'b1, 8'h80, 8'h00, 8'h00}, // R4 red
    {1'b1, 2'd2, 4'b1101, 1'b1, 8'h00, 8'h00, 8'h00}, // R3 unlit
    {1'b1, 2'd1, 4'b1010, 1'b0, 8'h00, 8'h00, 8'h00}, // R5 blank mono
    {1'b0, 2'd3, 4'b0110, 1'b1, 8'h80, 8'h40, 8'h00}, // R8 brown back
    {1'b1, 2'd3, 4'b0110, 1'b1, 8'h80, 8'h00, 8'h00}  // R8 no brown in mono
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic m, input logic [1:0] t, input logic [3:0] p,
                       input logic de, input logic hs, input logic vs);
    mono_mode = m; tint_sel = t; pix_rgbi = p; de_i = de; hs_i = hs; vs_i = vs;
  endtask

  function automatic logic [31:0] outs();
    return {5'd0, hs_o, vs_o, de_o, red_o, grn_o, blu_o};
  endfunction

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0;
    drive(1'b0, 2'd0, 4'b1111, 1'b1, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    chk("R7 in reset", outs(), 32'd0);

    // release away from edges; outputs stay zero for two edges
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 sync edge1", outs(), 32'd0);
    @(negedge clk);
    chk("R7 sync edge2", outs(), 32'd0);
    @(negedge clk);
    chk("R7 first capture", outs(), {5'd0, 3'b111, 24'hC0C0C0});

    // table walk: drive at falling edge, sample one edge later
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][31], VEC[i][30:29], VEC[i][28:25], VEC[i][24], i[0], i[1]);
      @(negedge clk);
      chk("R1 R2 R3 R4 R5 R8 colour", {8'd0, red_o, grn_o, blu_o}, {8'd0, VEC[i][23:0]});
      chk("R6 sync", {29'd0, hs_o, vs_o, de_o}, {29'd0, i[0], i[1], VEC[i][24]});
    end

    // R6 latency: change input, outputs still old before the edge
    drive(1'b0, 2'd0, 4'b0100, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    drive(1'b0, 2'd0, 4'b0001, 1'b1, 1'b1, 1'b0);
    #1;
    chk("R6 hold before edge", outs(), {5'd0, 3'b001, 24'h800000});
    @(negedge clk);
    chk("R6 after edge", outs(), {5'd0, 3'b101, 24'h000080});

    // R3: R and B ignored in mono with video off across all tints
    for (int t = 0; t < 4; t++) begin
      drive(1'b1, t[1:0], 4'b1101, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
      chk("R3 mono R/B ignored", {8'd0, red_o, grn_o, blu_o}, 32'd0);
    end

    // R7 async reset mid-run
    drive(1'b0, 2'd0, 4'b1111, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R7 async clear", outs(), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule